// File: doc/BRIEF.md
# LCD Power-Down Frame-Completion Handshake

This block sits between the system power manager and the LCD frame generator. When the power manager raises a power-down request, the block does not grant it straight away. It waits for the frame generator to signal the end of the frame in progress. Stopping the drive waveforms mid-frame would leave a DC component across the liquid crystal. Once that frame boundary is seen, the block sets a sticky ready flag. It raises an interrupt toward the power manager only when software has enabled it.

While the block sits in the powered-down state, a display-keep input chooses what the panel does. Either the glass stays driven, or the blank control is asserted so the panel is put out. Software clears the ready flag by writing a 1 to its status bit; a write of 0 leaves it alone. Dropping the request returns the block to idle at once and removes the interrupt. Gating of clocks is left to the surrounding logic.

Top module: `lcd_pd_handshake`

## Requirements
- R1: After a synchronous active-low reset, `pd_ready`, `pd_irq` and `disp_blank` are all 0, and the block is idle.
- R2: A request held high without `frame_end` keeps `pd_ready` at 0. The first clock edge where `pd_req` and `frame_end` are both 1 completes the frame, and `pd_ready` reads 1 right after that edge.
- R3: If `pd_req` and `frame_end` are first high in the same cycle, that frame counts as the completing frame: `pd_ready` is 1 after that single edge.
- R4: `pd_irq` equals `pd_ready AND irq_en` while the block is powered down, following `irq_en` without delay. With `irq_en` at 0 the interrupt is blocked, but `pd_ready` still reads 1.
- R5: While powered down, `disp_blank` is 1 when `keep_disp` is 0 and 0 when `keep_disp` is 1. Outside the powered-down state, `disp_blank` is 0.
- R6: Sampling `pd_req` at 0 on an edge returns the block to idle. After that edge, `pd_irq` and `disp_blank` are 0, while `pd_ready` keeps its value until it is cleared.
- R7: A status write (`clr_wr`=1) with `clr_data`=1 clears `pd_ready` after that edge, and `pd_irq` falls with it.
- R8: A status write with `clr_data`=0 has no effect on `pd_ready` or `pd_irq`.
- R9: When a frame completes on the same edge as a clearing write, the set wins and `pd_ready` reads 1.
- R10: A new request that starts waiting for a frame end clears a stale `pd_ready` left from an earlier power-down, so the flag reads 0 while that frame is incomplete.
- R11: A `frame_end` pulse without a request changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_req | input | 1 | Power-down request from the power manager, held as a level |
| frame_end | input | 1 | One-cycle pulse at the last cycle of a frame |
| irq_en | input | 1 | Interrupt enable |
| keep_disp | input | 1 | 1: keep the panel driven while powered down |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 1 | Value written to the ready status bit (1 clears) |
| pd_ready | output | 1 | Sticky ready-for-power-down status |
| pd_irq | output | 1 | Power-down interrupt to the power manager |
| disp_blank | output | 1 | 1: put the panel out |

## Verification
The bench targets several corner cases, each of which catches a specific kind of error.
- A request that arrives in the same cycle as a frame end must complete at once. A design that counts only later pulses would keep `pd_ready` at 0 after that edge.
- A clearing write that lands on the completing edge must lose to the set. The wrong priority would show up as a missing ready flag.
- A stale flag must be dropped when a fresh request starts waiting. A design that keeps the flag would report ready before the frame finishes.
- Writes of 0 must be ignored. A design that treats any write as a clear would lose the flag.
- `frame_end` pulses without a request must do nothing, and dropping the request must silence both the interrupt and the blank control. Any leftover output here shows up as a mismatch.

// File: rtl/lcd_pd_pkg.sv
// Shared types for the LCD power-down handshake.
// Assumes: three states are enough to track a request through one frame.
package lcd_pd_pkg;

    typedef enum logic [1:0] {
        PD_IDLE       = 2'd0,
        PD_WAIT_FRAME = 2'd1,
        PD_DOWN       = 2'd2
    } pd_state_e;

endpackage

// File: rtl/lcd_pd_fsm.sv
// Request sequencer: follows a power-down request from idle, through waiting
// for the frame boundary, to powered down.
// Assumes: pd_req is a level held by the power manager; frame_end is a single
// cycle pulse on the frame's last cycle.
module lcd_pd_fsm
    import lcd_pd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_req,
    input  logic      frame_end,
    output pd_state_e state,
    output logic      enter_down,
    output logic      enter_wait
);

    pd_state_e state_nx;

    // Next-state decode and entry strobes.
    always_comb begin
        state_nx   = state;
        enter_down = 1'b0;
        enter_wait = 1'b0;
        if (!pd_req) begin
            state_nx = PD_IDLE;
        end else begin
            case (state)
                PD_IDLE: begin
                    if (frame_end) begin
                        state_nx   = PD_DOWN;
                        enter_down = 1'b1;
                    end else begin
                        state_nx   = PD_WAIT_FRAME;
                        enter_wait = 1'b1;
                    end
                end
                PD_WAIT_FRAME: begin
                    if (frame_end) begin
                        state_nx   = PD_DOWN;
                        enter_down = 1'b1;
                    end
                end
                PD_DOWN: state_nx = PD_DOWN;
                default: state_nx = PD_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_IDLE;
        else        state <= state_nx;
    end

    // R2: a frame end during the wait leads to powered down.
    a_r2_wait_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAIT_FRAME && pd_req && frame_end) |=> (state == PD_DOWN));

    // R6: a dropped request always returns to idle.
    a_r6_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_req |=> (state == PD_IDLE));

    // R11: frame ends without a request never leave idle.
    a_r11_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_IDLE && !pd_req && frame_end) |=> (state == PD_IDLE));

endmodule

// File: rtl/lcd_pd_status.sv
// Sticky ready flag: set on entering power down, cleared by a write of one or
// by the start of a new wait. A set on the same edge beats any clear.
// Assumes: enter_down and enter_wait are never high together.
module lcd_pd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_down,
    input  logic enter_wait,
    input  logic clr_wr,
    input  logic clr_data,
    output logic ready_q
);

    logic clr_hit;

    // Write-one-to-clear decode; a zero write is ignored.
    always_comb clr_hit = clr_wr & clr_data;

    // Flag register with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ready_q <= 1'b0;
        else if (enter_down)           ready_q <= 1'b1;
        else if (clr_hit || enter_wait) ready_q <= 1'b0;
    end

    // R9: completion beats a simultaneous clear.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_down && clr_wr && clr_data) |=> ready_q);

    // R7: a clear without a set empties the flag.
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data && !enter_down) |=> !ready_q);

endmodule

// File: rtl/lcd_pd_outputs.sv
// Output shaping: gates the interrupt with its enable and drives the blank
// control from the display-keep choice, both only while powered down.
// Assumes: combinational paths from irq_en and keep_disp are acceptable.
module lcd_pd_outputs
    import lcd_pd_pkg::*;
(
    input  pd_state_e state,
    input  logic      ready_q,
    input  logic      irq_en,
    input  logic      keep_disp,
    output logic      pd_irq,
    output logic      disp_blank
);

    logic is_down;

    // Interrupt and blank decode.
    always_comb begin
        is_down    = (state == PD_DOWN);
        pd_irq     = is_down & ready_q & irq_en;
        disp_blank = is_down & ~keep_disp;
    end

endmodule

// File: rtl/lcd_pd_handshake.sv
// Top of the LCD power-down handshake: defers a power-down grant to the next
// frame boundary, reports it through a sticky flag and a gated interrupt, and
// blanks or keeps the panel while powered down.
// Assumes: single clock domain; inputs already synchronised.
module lcd_pd_handshake
    import lcd_pd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic frame_end,
    input  logic irq_en,
    input  logic keep_disp,
    input  logic clr_wr,
    input  logic clr_data,
    output logic pd_ready,
    output logic pd_irq,
    output logic disp_blank
);

    pd_state_e state;
    logic      enter_down;
    logic      enter_wait;

    lcd_pd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (pd_req),
        .frame_end  (frame_end),
        .state      (state),
        .enter_down (enter_down),
        .enter_wait (enter_wait)
    );

    lcd_pd_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_down (enter_down),
        .enter_wait (enter_wait),
        .clr_wr     (clr_wr),
        .clr_data   (clr_data),
        .ready_q    (pd_ready)
    );

    lcd_pd_outputs u_out (
        .state      (state),
        .ready_q    (pd_ready),
        .irq_en     (irq_en),
        .keep_disp  (keep_disp),
        .pd_irq     (pd_irq),
        .disp_blank (disp_blank)
    );

    // R1/R2: readiness only rises after a frame end seen with the request.
    a_r2_rise_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_ready) |-> ($past(pd_req) && $past(frame_end)));

    // R10: never ready while still waiting for the frame.
    a_r10_wait_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_WAIT_FRAME) |-> !pd_ready);

    // R4: the interrupt needs both its enable and the flag.
    a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pd_irq |-> (irq_en && pd_ready));

    // R5: blanking only happens when the panel is not kept.
    a_r5_keep_disp: assert property (@(posedge clk) disable iff (!rst_n)
        disp_blank |-> !keep_disp);

    // R6: no interrupt after a dropped request.
    a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_req |=> !pd_irq);

    // R8: a zero write while powered down keeps the flag.
    a_r8_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_DOWN && pd_req && pd_ready && !(clr_wr && clr_data)) |=> pd_ready);

endmodule

// File: tb/lcd_pd_handshake_tb.sv
module lcd_pd_handshake_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b0, frame_end = 1'b0, irq_en = 1'b0, keep_disp = 1'b0;
    logic clr_wr = 1'b0, clr_data = 1'b0;
    logic pd_ready, pd_irq, disp_blank;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    lcd_pd_handshake u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .frame_end(frame_end),
        .irq_en(irq_en), .keep_disp(keep_disp), .clr_wr(clr_wr),
        .clr_data(clr_data), .pd_ready(pd_ready), .pd_irq(pd_irq),
        .disp_blank(disp_blank)
    );

    // Entry: tag[12:9] req fe en keep cw cd | exp ready irq blank
    localparam int NV = 14;
    localparam logic [12:0] VEC [NV] = '{
        {4'd2,  6'b1_0_1_0_0_0, 3'b000},  // R2 wait starts
        {4'd2,  6'b1_0_1_0_0_0, 3'b000},  // R2 still waiting
        {4'd2,  6'b1_1_1_0_0_0, 3'b111},  // R2 frame completes
        {4'd2,  6'b1_1_1_0_0_0, 3'b111},  // R2 later frame end, no change
        {4'd4,  6'b1_0_0_0_0_0, 3'b101},  // R4 interrupt blocked
        {4'd5,  6'b1_0_1_1_0_0, 3'b110},  // R5 panel kept
        {4'd8,  6'b1_0_1_1_1_0, 3'b110},  // R8 zero write ignored
        {4'd7,  6'b1_0_1_0_1_1, 3'b001},  // R7 clear
        {4'd6,  6'b0_0_1_0_0_0, 3'b000},  // R6 drop
        {4'd11, 6'b0_1_1_0_0_0, 3'b000},  // R11 frame end without request
        {4'd3,  6'b1_1_1_0_0_0, 3'b111},  // R3 same-cycle completion
        {4'd6,  6'b0_0_1_0_0_0, 3'b100},  // R6 drop keeps flag
        {4'd10, 6'b1_0_1_0_0_0, 3'b000},  // R10 stale flag cleared
        {4'd9,  6'b1_1_1_0_1_1, 3'b111}   // R9 set beats clear
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ready/irq/blank = %b, expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d, expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {pd_ready, pd_irq, disp_blank}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {pd_req, frame_end, irq_en, keep_disp, clr_wr, clr_data} = VEC[i][8:3];
            @(posedge clk);
            #1;
            check($sformatf("R%0d step %0d", VEC[i][12:9], i),
                  {pd_ready, pd_irq, disp_blank}, VEC[i][2:0]);
        end
        // R1: reset from the powered-down state clears everything.
        @(negedge clk);
        {pd_req, frame_end, irq_en, keep_disp, clr_wr, clr_data} = 6'b1_0_1_0_0_0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 mid-run reset", {pd_ready, pd_irq, disp_blank}, 3'b000);
        // R4: enable toggled live while powered down.
        @(negedge clk);
        rst_n = 1'b1;
        frame_end = 1'b1;
        @(posedge clk);
        #1;
        check("R3 completion after reset", {pd_ready, pd_irq, disp_blank}, 3'b111);
        @(negedge clk);
        frame_end = 1'b0;
        irq_en = 1'b0;
        #1;
        check("R4 enable off live", {pd_ready, pd_irq, disp_blank}, 3'b101);
        irq_en = 1'b1;
        #1;
        check("R4 enable on live", {pd_ready, pd_irq, disp_blank}, 3'b111);
        keep_disp = 1'b1;
        #1;
        check("R5 keep live", {pd_ready, pd_irq, disp_blank}, 3'b110);
        finish_run();
    end

endmodule